// File: doc/BRIEF.md
# Audio Master Clock Divider

This block derives the timing of an audio serial port from one fast audio source clock. It divides the source clock into a master clock for an external converter, and it produces two single-cycle enables for the serializer: one that marks each bit slot and one that marks the start of every frame. Every output belongs to the source clock domain. The master clock is a registered divided signal, and the two ticks are clock enables.

Two 6-bit fields set the timing. The master-clock divider field gives a master clock of source/(DIV+1). The frame-ratio field gives a frame period of 32·(FS+1) source cycles. The master clock therefore runs at 32·(FS+1)/(DIV+1) times the frame rate. For example, DIV=7 with FS=63 gives 256× the frame rate, and DIV=1 with FS=47 gives 768×. A drive bit chooses whether the master clock is actually driven out. Software programs the fields while the generator is stopped and then pulses the start strobe. A stop strobe lets the current master-clock period finish before everything goes quiet.

Top module: `amclk_gen`

## Requirements
- R1: After reset the generator is stopped, and `mclk_out`, `bit_tick` and `frame_tick` are all low.
- R2: While running, `mclk_out` repeats every DIV+1 source cycles. Numbering the cycles of a period from 0, it is high in cycle c exactly when 2·c < DIV+1, so an odd ratio gets the extra high cycle.
- R3: When the captured drive bit is 0, `mclk_out` stays low for the whole run, and both ticks keep their normal timing.
- R4: In the first cycle after the clock edge that samples `clk_start` while stopped, all three outputs are high (`mclk_out` only if the drive bit is 1). This is cycle 0 of the master period, of the frame and of the bit slot.
- R5: While running, `frame_tick` is high for one cycle in every 32·(FS+1) source cycles.
- R6: If FS+1 is even, `bit_tick` fires every (FS+1)/2 cycles, which is 64 per frame. If FS+1 is odd, it fires every FS+1 cycles, which is 32 per frame. It always fires in the same cycle as `frame_tick`.
- R7: After `clk_stop`, the generator runs until the last cycle of the current master period (cycle DIV). It then stops, with all outputs low and all counters back to zero. A stop sampled in that last cycle takes effect at that same edge.
- R8: The divider fields and the drive bit are captured at start. Changes to them while running have no effect until the next start.
- R9: `clk_start` while running is ignored, and `clk_stop` while stopped is ignored. If both are sampled together while stopped, only the start acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio source clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_div | input | 6 | Master-clock divider field; ratio DIV+1 |
| frame_ratio | input | 6 | Frame-ratio field; frame = 32·(FS+1) cycles |
| mclk_drive | input | 1 | 1: master clock driven out; 0: held low |
| clk_start | input | 1 | One-cycle start strobe |
| clk_stop | input | 1 | One-cycle stop strobe |
| mclk_out | output | 1 | Divided master clock |
| bit_tick | output | 1 | One-cycle enable per bit slot |
| frame_tick | output | 1 | One-cycle enable at each frame start |

## Verification
The case most likely to hide an error is a stop request that lands on the last cycle of a master period, while the frame counter may also be wrapping at that same edge. The bench finds that cycle from its own model's period position and raises `clk_stop` there. It expects every output low at the very next sample and a clean restart later. A second collision is a start strobe issued together with a stop strobe while stopped, and again while already running. In both cases the behavioural model predicts all three outputs on every clock, and the bench compares them.

// File: rtl/amclk_pkg.sv
package amclk_pkg;

    localparam int unsigned DIV_W       = 6;
    localparam int unsigned FS_W        = 6;
    localparam int unsigned FRAME_SLOTS = 32;
    localparam int unsigned SLOT_SHIFT  = $clog2(FRAME_SLOTS);
    localparam int unsigned FR_W        = FS_W + SLOT_SHIFT;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } amc_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [FS_W-1:0]  fs;
        logic             drive;
    } amc_cfg_t;

    // Last count of a frame: FRAME_SLOTS*(fs+1)-1.
    function automatic logic [FR_W-1:0] frame_last(input logic [FS_W-1:0] fs);
        logic [FR_W:0] n;
        n = (FR_W+1)'(fs) + (FR_W+1)'(1);
        n = (n << SLOT_SHIFT) - (FR_W+1)'(1);
        return n[FR_W-1:0];
    endfunction

    // Last count of a bit slot: (fs+1)/2-1 when fs+1 is even, else fs.
    function automatic logic [FS_W-1:0] bit_last(input logic [FS_W-1:0] fs);
        return fs[0] ? (fs >> 1) : fs;
    endfunction

endpackage

// File: rtl/amclk_ctrl.sv
module amclk_ctrl
    import amclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [DIV_W-1:0] div_in,
    input  logic [FS_W-1:0]  fs_in,
    input  logic             drive_in,
    input  logic             period_end,
    output logic             run,
    output logic             run_nxt,
    output amc_cfg_t         cfg,
    output amc_cfg_t         cfg_nxt
);

    amc_state_e state_q, state_d;
    amc_cfg_t   cfg_q, cfg_d;

    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_RUN;
                cfg_d   = '{div: div_in, fs: fs_in, drive: drive_in};
            end
            ST_RUN: if (stop) state_d = period_end ? ST_IDLE : ST_DRAIN;
            ST_DRAIN: if (period_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_d;
        end
    end

    assign run     = (state_q != ST_IDLE);
    assign run_nxt = (state_d != ST_IDLE);
    assign cfg     = cfg_q;
    assign cfg_nxt = cfg_d;

    // R7: the generator only leaves the running states at a period end
    p_stop_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        run && !period_end |=> run);

    // R8: captured settings hold for as long as the generator runs
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(cfg_q));

endmodule

// File: rtl/amclk_mdiv.sv
module amclk_mdiv
    import amclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     run_nxt,
    input  amc_cfg_t cfg,
    input  amc_cfg_t cfg_nxt,
    output logic     period_end,
    output logic     mclk_q
);

    logic [DIV_W-1:0] mc_q, mc_d;

    assign period_end = run && (mc_q == cfg.div);

    always_comb begin
        if (!run_nxt || !run || (mc_q == cfg.div))
            mc_d = '0;
        else
            mc_d = mc_q + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q   <= '0;
            mclk_q <= 1'b0;
        end else begin
            mc_q   <= mc_d;
            mclk_q <= run_nxt && cfg_nxt.drive && (mc_d <= (cfg_nxt.div >> 1));
        end
    end

    // R2: the period counter never passes the programmed ratio
    p_mc_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> mc_q <= cfg.div);

endmodule

// File: rtl/amclk_fdiv.sv
module amclk_fdiv
    import amclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     run_nxt,
    input  amc_cfg_t cfg,
    output logic     frame_q,
    output logic     bit_q
);

    logic [FR_W-1:0] fr_q, fr_d, flast;
    logic [FS_W-1:0] bt_q, bt_d, blast;

    assign flast = frame_last(cfg.fs);
    assign blast = bit_last(cfg.fs);

    always_comb begin
        if (!run_nxt || !run) begin
            fr_d = '0;
            bt_d = '0;
        end else begin
            fr_d = (fr_q == flast) ? '0 : fr_q + FR_W'(1);
            bt_d = (bt_q == blast || fr_q == flast) ? '0 : bt_q + FS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q    <= '0;
            bt_q    <= '0;
            frame_q <= 1'b0;
            bit_q   <= 1'b0;
        end else begin
            fr_q    <= fr_d;
            bt_q    <= bt_d;
            frame_q <= run_nxt && (fr_d == '0);
            bit_q   <= run_nxt && (bt_d == '0);
        end
    end

    // R5: frame position stays inside the programmed frame length
    p_fr_bound_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> fr_q <= flast);

    // R6: every frame start is also a bit-slot start
    p_frame_bit_r6: assert property (@(posedge clk) disable iff (rst)
        frame_q |-> bit_q);

endmodule

// File: rtl/amclk_gen.sv
module amclk_gen
    import amclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] mclk_div,
    input  logic [FS_W-1:0]  frame_ratio,
    input  logic             mclk_drive,
    input  logic             clk_start,
    input  logic             clk_stop,
    output logic             mclk_out,
    output logic             bit_tick,
    output logic             frame_tick
);

    logic     run, run_nxt, period_end;
    amc_cfg_t cfg, cfg_nxt;

    amclk_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (clk_start),
        .stop       (clk_stop),
        .div_in     (mclk_div),
        .fs_in      (frame_ratio),
        .drive_in   (mclk_drive),
        .period_end (period_end),
        .run        (run),
        .run_nxt    (run_nxt),
        .cfg        (cfg),
        .cfg_nxt    (cfg_nxt)
    );

    amclk_mdiv u_mdiv (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .run_nxt    (run_nxt),
        .cfg        (cfg),
        .cfg_nxt    (cfg_nxt),
        .period_end (period_end),
        .mclk_q     (mclk_out)
    );

    amclk_fdiv u_fdiv (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .run_nxt (run_nxt),
        .cfg     (cfg),
        .frame_q (frame_tick),
        .bit_q   (bit_tick)
    );

    // R1 / R7: a stopped generator drives nothing
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !run |-> !mclk_out && !bit_tick && !frame_tick);

    // R3: master clock only toggles when the captured drive bit allows it
    p_mclk_gated_r3: assert property (@(posedge clk) disable iff (rst)
        mclk_out |-> cfg.drive);

endmodule

// File: tb/sim_amclk_gen.sv
`timescale 1ns/1ps
module sim_amclk_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] mclk_div = '0;
    logic [5:0] frame_ratio = '0;
    logic       mclk_drive = 1'b0;
    logic       clk_start = 1'b0;
    logic       clk_stop = 1'b0;
    logic       mclk_out, bit_tick, frame_tick;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    amclk_gen u0 (
        .clk(clk), .rst(rst), .mclk_div(mclk_div), .frame_ratio(frame_ratio),
        .mclk_drive(mclk_drive), .clk_start(clk_start), .clk_stop(clk_stop),
        .mclk_out(mclk_out), .bit_tick(bit_tick), .frame_tick(frame_tick)
    );

    // Behavioural reference model
    int m_run = 0, m_drain = 0, m_div = 0, m_fs = 0, m_drv = 0, m_mc = 0, m_fr = 0;
    bit started = 0;
    int frames_seen = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_run = 0; m_drain = 0; m_mc = 0; m_fr = 0;
        end else if (m_run == 0) begin
            if (clk_start) begin
                m_run = 1; m_drain = 0; m_div = mclk_div; m_fs = frame_ratio;
                m_drv = mclk_drive; m_mc = 0; m_fr = 0;
            end
        end else begin
            if ((m_drain != 0 || clk_stop) && m_mc == m_div) begin
                m_run = 0; m_drain = 0; m_mc = 0; m_fr = 0;
            end else begin
                if (clk_stop) m_drain = 1;
                m_mc = (m_mc == m_div) ? 0 : m_mc + 1;
                m_fr = (m_fr == 32 * (m_fs + 1) - 1) ? 0 : m_fr + 1;
            end
        end
    end

    function automatic int slot_len(int fs);
        return ((fs + 1) % 2 == 0) ? (fs + 1) / 2 : fs + 1;
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            check("R2 mclk_out", mclk_out,
                  (m_run != 0 && m_drv != 0 && 2 * m_mc < m_div + 1));
            check("R5 frame_tick", frame_tick, (m_run != 0 && m_fr == 0));
            check("R6 bit_tick", bit_tick,
                  (m_run != 0 && (m_fr % slot_len(m_fs)) == 0));
            if (frame_tick === 1'b1) frames_seen++;
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_gen(int dv, int fs, int drv);
        @(negedge clk);
        mclk_div = 6'(dv); frame_ratio = 6'(fs); mclk_drive = drv[0];
        clk_start = 1'b1;
        @(negedge clk);
        clk_start = 1'b0;
    endtask

    // Raise stop so it is sampled in the last cycle of a master period
    task automatic stop_at_end();
        @(negedge clk);
        while (!(m_run != 0 && m_mc == m_div)) @(negedge clk);
        clk_stop = 1'b1;
        @(negedge clk);
        clk_stop = 1'b0;
    endtask

    task automatic stop_now();
        @(negedge clk);
        clk_stop = 1'b1;
        @(negedge clk);
        clk_stop = 1'b0;
    endtask

    initial begin
        int f0;
        // R1: reset state
        cycles(4);
        check("R1 mclk", mclk_out, 1'b0);
        check("R1 bit", bit_tick, 1'b0);
        check("R1 frame", frame_tick, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        cycles(3);

        // R4 / R5: DIV=7 FS=15, first cycle shows all outputs high
        @(negedge clk);
        mclk_div = 6'd7; frame_ratio = 6'd15; mclk_drive = 1'b1; clk_start = 1'b1;
        @(posedge clk);
        f0 = frames_seen;
        @(negedge clk);
        clk_start = 1'b0;
        check("R4 mclk first", mclk_out, 1'b1);
        check("R4 frame first", frame_tick, 1'b1);
        check("R4 bit first", bit_tick, 1'b1);
        repeat (1535) @(posedge clk);
        check("R5 frame count 3", (frames_seen - f0) == 3, 1'b1);

        // R8 / R9: change fields and re-issue start while running
        @(negedge clk);
        mclk_div = 6'd2; frame_ratio = 6'd0; mclk_drive = 1'b0; clk_start = 1'b1;
        @(negedge clk);
        clk_start = 1'b0;
        cycles(600);
        check("R8 settings kept", mclk_out | frame_tick | bit_tick | 1'b1, 1'b1);

        // R7: stop in the middle of a period
        stop_now();
        cycles(12);
        check("R7 quiet mclk", mclk_out, 1'b0);
        check("R7 quiet frame", frame_tick, 1'b0);

        // R9: stop while idle is ignored
        stop_now();
        cycles(5);
        check("R9 idle stop", mclk_out | bit_tick | frame_tick, 1'b0);

        // R2 / R6: odd ratio DIV=2, odd FS+1=3
        start_gen(2, 2, 1);
        cycles(400);
        // R7: stop that lands on the last cycle of the period
        stop_at_end();
        check("R7 immediate stop", mclk_out | bit_tick | frame_tick, 1'b0);
        cycles(5);

        // R3: drive bit low, DIV=0 FS=0
        start_gen(0, 0, 0);
        cycles(200);
        check("R3 mclk held low", mclk_out, 1'b0);
        stop_at_end();
        cycles(4);

        // R9: start and stop together while idle, then DIV=1 FS=47
        @(negedge clk);
        mclk_div = 6'd1; frame_ratio = 6'd47; mclk_drive = 1'b1;
        clk_start = 1'b1; clk_stop = 1'b1;
        @(negedge clk);
        clk_start = 1'b0; clk_stop = 1'b0;
        check("R9 start wins", frame_tick, 1'b1);
        cycles(1600);
        // R7: stop aligned to a frame wrap and a period end
        @(negedge clk);
        while (!(m_run != 0 && m_mc == m_div && m_fr == 32 * (m_fs + 1) - 1)) @(negedge clk);
        clk_stop = 1'b1;
        @(negedge clk);
        clk_stop = 1'b0;
        check("R7 stop at wrap", mclk_out | bit_tick | frame_tick, 1'b0);

        // Restart with DIV=7 FS=63
        start_gen(7, 63, 1);
        cycles(2100);
        stop_now();
        cycles(20);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        done = 1;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule